// File: doc/BRIEF.md
# Tablewalk-Assisted TLB Loader

This block sits beside a small software-managed TLB and shortens the miss handler. When a translation miss occurs, the faulting effective page number is latched together with the current address-space ID. Software then reads two registers that do the address arithmetic for it. The first read gives the address of the level-1 descriptor. The second gives the address of the page-table entry within the level-2 table.

Software loads the level-2 base and the page attributes into one register. It then writes the real page number. That single write commits a complete TLB entry on the write bus one cycle later, at the index held in the control register. The index then steps down, wrapping modulo 32. An optional reserve flag keeps the four lowest slots out of the rotation. The TLB array itself lies outside the block.

Top module: `tw_tlb_loader`

## Requirements
- R1: After reset the control register (select 0) reads 0x04000000, which means load index 0 and reserve flag clear. The context (select 1), page-number (select 2), level-1 (select 3) and level-2 (select 4) registers read 0. `tlb_we` is low.
- R2: A write to the control register stores all 32 bits, and it reads back unchanged. The load index is bits 12:8 and the reserve flag is bit 27.
- R3: The context register keeps the address-space ID in bits 3:0. Its other bits read as 0.
- R4: A software write to the page-number register keeps bits 31:12 (page), bit 9 (entry valid) and bits 3:0 (ASID). Its other bits read as 0.
- R5: A `miss_valid` pulse loads `miss_page` into the page field, copies the context ASID and sets the valid bit. It takes priority over a software write to the page-number register in the same cycle.
- R6: Reading select 3 returns {level-1 base bits 31:12, page bits 19:10, 2'b00}. Only bits 31:12 of a write are stored there.
- R7: Reading select 4 returns {level-2 base bits 31:12, page bits 9:0, 2'b00}.
- R8: A write to select 5 (real page number) raises `tlb_we` for exactly the next cycle. In that cycle `tlb_idx` is the load index before the write, and `tlb_epn`, `tlb_asid` and `tlb_ev` come from the page-number register. `tlb_rpn` is the written value.
- R9: The entry attributes come from level-2 register bits 8:5 (access group), bit 4 (guarded), bits 3:2 (size: 11 is 8 MB, 01 is 512 KB, 00 is 4 KB or 16 KB), bit 1 (write-through) and bit 0 (segment valid).
- R10: After each entry write, the load index decrements modulo 32. Index 0 is followed by 31.
- R11: With the reserve flag set, a decrement that would land below 4 yields 31 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_sel | input | 3 | Register select (0 ctrl, 1 context, 2 page, 3 level-1, 4 level-2, 5 real page) |
| sr_wr | input | 1 | Write strobe for the selected register |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Combinational read data for the selected register |
| miss_valid | input | 1 | Miss capture pulse |
| miss_page | input | 20 | Faulting effective page number |
| tlb_we | output | 1 | TLB entry write strobe |
| tlb_idx | output | 5 | TLB slot to load |
| tlb_epn | output | 20 | Entry effective page |
| tlb_asid | output | 4 | Entry address-space ID |
| tlb_ev | output | 1 | Entry valid |
| tlb_grp | output | 4 | Access group |
| tlb_guard | output | 1 | Guarded storage |
| tlb_size | output | 2 | Page size code |
| tlb_wt | output | 1 | Write-through |
| tlb_sv | output | 1 | Segment valid |
| tlb_rpn | output | 32 | Real page number word as written |

## Verification
The properties assume that the select never holds a value above 5 while `sr_wr` is high. They also assume that a miss pulse lasts one cycle, so that each capture stands alone. The directed bench drives only defined selects. It raises `miss_valid` for single cycles only, except in the one deliberate overlap with a page-number write. Every write and miss is issued on a falling edge, and results are sampled on the next falling edge, after the registering edge.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam logic [2:0] SEL_CTRL = 3'd0;
   localparam logic [2:0] SEL_CTX  = 3'd1;
   localparam logic [2:0] SEL_EPN  = 3'd2;
   localparam logic [2:0] SEL_L1   = 3'd3;
   localparam logic [2:0] SEL_L2   = 3'd4;
   localparam logic [2:0] SEL_RPN  = 3'd5;

   localparam int IDX_LSB  = 8;
   localparam int RSV_BIT  = 27;
   localparam int EV_BIT   = 9;
   localparam int PAGE_W   = 20;
   localparam int L1_IDX_W = 10;

   typedef struct packed {
      logic [3:0] grp;
      logic       guard;
      logic [1:0] size;
      logic       wt;
      logic       sv;
   } attr_t;
endpackage

// File: rtl/tw_index_seq.sv
module tw_index_seq
   import tw_pkg::*;
#(
   parameter int          IDX_W    = 5,
   parameter int          RSV_CNT  = 4,
   parameter logic [31:0] CTRL_RST = 32'h0400_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic [31:0]      wdata,
   input  logic             adv,
   output logic [31:0]      ctrl_q,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] RSV_L = IDX_W'(RSV_CNT);

   logic [IDX_W-1:0] dec;
   logic [IDX_W-1:0] nxt;

   assign idx = ctrl_q[IDX_LSB +: IDX_W];
   assign dec = idx - 1'b1;

   generate
      if (RSV_CNT == 0) begin : g_plain
         assign nxt = dec;
      end else begin : g_skip
         assign nxt = (ctrl_q[RSV_BIT] && (dec < RSV_L)) ? '1 : dec;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= CTRL_RST;
      else if (wr_ctrl)
         ctrl_q <= wdata;
      else if (adv)
         ctrl_q[IDX_LSB +: IDX_W] <= nxt;
   end
endmodule

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
   import tw_pkg::*;
#(
   parameter int ASID_W = 4
) (
   input  logic [2:0]        sel,
   input  logic [31:0]       ctrl_q,
   input  logic [ASID_W-1:0] ctx_asid,
   input  logic [PAGE_W-1:0] epn_page,
   input  logic              epn_ev,
   input  logic [ASID_W-1:0] epn_asid,
   input  logic [PAGE_W-1:0] l1_base,
   input  logic [PAGE_W-1:0] l2_base,
   output logic [31:0]       rdata
);
   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CTRL: rdata = ctrl_q;
         SEL_CTX:  rdata[ASID_W-1:0] = ctx_asid;
         SEL_EPN: begin
            rdata[31:12]        = epn_page;
            rdata[EV_BIT]       = epn_ev;
            rdata[ASID_W-1:0]   = epn_asid;
         end
         SEL_L1:   rdata = {l1_base, epn_page[PAGE_W-1 -: L1_IDX_W], 2'b00};
         SEL_L2:   rdata = {l2_base, epn_page[L1_IDX_W-1:0], 2'b00};
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/tw_entry_out.sv
module tw_entry_out
   import tw_pkg::*;
#(
   parameter int IDX_W  = 5,
   parameter int ASID_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [IDX_W-1:0]  idx,
   input  logic [PAGE_W-1:0] epn_page,
   input  logic [ASID_W-1:0] epn_asid,
   input  logic              epn_ev,
   input  attr_t             attr,
   input  logic [31:0]       rpn,
   output logic              tlb_we,
   output logic [IDX_W-1:0]  tlb_idx,
   output logic [PAGE_W-1:0] tlb_epn,
   output logic [ASID_W-1:0] tlb_asid,
   output logic              tlb_ev,
   output attr_t             tlb_attr,
   output logic [31:0]       tlb_rpn
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tlb_we   <= 1'b0;
         tlb_idx  <= '0;
         tlb_epn  <= '0;
         tlb_asid <= '0;
         tlb_ev   <= 1'b0;
         tlb_attr <= '0;
         tlb_rpn  <= '0;
      end else begin
         tlb_we <= commit;
         if (commit) begin
            tlb_idx  <= idx;
            tlb_epn  <= epn_page;
            tlb_asid <= epn_asid;
            tlb_ev   <= epn_ev;
            tlb_attr <= attr;
            tlb_rpn  <= rpn;
         end
      end
   end
endmodule

// File: rtl/tw_tlb_loader.sv
module tw_tlb_loader
   import tw_pkg::*;
#(
   parameter int          IDX_W    = 5,
   parameter int          ASID_W   = 4,
   parameter int          RSV_CNT  = 4,
   parameter logic [31:0] CTRL_RST = 32'h0400_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        sr_sel,
   input  logic              sr_wr,
   input  logic [31:0]       sr_wdata,
   output logic [31:0]       sr_rdata,
   input  logic              miss_valid,
   input  logic [19:0]       miss_page,
   output logic              tlb_we,
   output logic [IDX_W-1:0]  tlb_idx,
   output logic [19:0]       tlb_epn,
   output logic [ASID_W-1:0] tlb_asid,
   output logic              tlb_ev,
   output logic [3:0]        tlb_grp,
   output logic              tlb_guard,
   output logic [1:0]        tlb_size,
   output logic              tlb_wt,
   output logic              tlb_sv,
   output logic [31:0]       tlb_rpn
);
   generate
      if (IDX_W < 1 || IDX_W > 5) begin : g_bad_idx
         $error("IDX_W must fit the 5-bit index field");
      end
      if (ASID_W < 1 || ASID_W > 4) begin : g_bad_asid
         $error("ASID_W must fit the 4-bit ASID field");
      end
      if (RSV_CNT < 0 || RSV_CNT >= (1 << IDX_W)) begin : g_bad_rsv
         $error("RSV_CNT must be below the index range");
      end
   endgenerate

   logic              wr_ctrl, wr_ctx, wr_epn, wr_l1, wr_l2, commit;
   logic [31:0]       ctrl_q;
   logic [IDX_W-1:0]  idx;
   logic [ASID_W-1:0] ctx_asid;
   logic [PAGE_W-1:0] epn_page;
   logic              epn_ev;
   logic [ASID_W-1:0] epn_asid;
   logic [PAGE_W-1:0] l1_base;
   logic [PAGE_W-1:0] l2_base;
   attr_t             attr;
   attr_t             tlb_attr;

   assign wr_ctrl = sr_wr && (sr_sel == SEL_CTRL);
   assign wr_ctx  = sr_wr && (sr_sel == SEL_CTX);
   assign wr_epn  = sr_wr && (sr_sel == SEL_EPN);
   assign wr_l1   = sr_wr && (sr_sel == SEL_L1);
   assign wr_l2   = sr_wr && (sr_sel == SEL_L2);
   assign commit  = sr_wr && (sr_sel == SEL_RPN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_asid <= '0;
         epn_page <= '0;
         epn_ev   <= 1'b0;
         epn_asid <= '0;
         l1_base  <= '0;
         l2_base  <= '0;
         attr     <= '0;
      end else begin
         if (wr_ctx) ctx_asid <= sr_wdata[ASID_W-1:0];
         if (miss_valid) begin
            epn_page <= miss_page;
            epn_ev   <= 1'b1;
            epn_asid <= ctx_asid;
         end else if (wr_epn) begin
            epn_page <= sr_wdata[31:12];
            epn_ev   <= sr_wdata[EV_BIT];
            epn_asid <= sr_wdata[ASID_W-1:0];
         end
         if (wr_l1) l1_base <= sr_wdata[31:12];
         if (wr_l2) begin
            l2_base <= sr_wdata[31:12];
            attr    <= attr_t'(sr_wdata[8:0]);
         end
      end
   end

   tw_index_seq #(.IDX_W(IDX_W), .RSV_CNT(RSV_CNT), .CTRL_RST(CTRL_RST)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(sr_wdata),
      .adv(commit), .ctrl_q(ctrl_q), .idx(idx)
   );

   tw_addr_gen #(.ASID_W(ASID_W)) u_rd (
      .sel(sr_sel), .ctrl_q(ctrl_q), .ctx_asid(ctx_asid), .epn_page(epn_page),
      .epn_ev(epn_ev), .epn_asid(epn_asid), .l1_base(l1_base), .l2_base(l2_base),
      .rdata(sr_rdata)
   );

   tw_entry_out #(.IDX_W(IDX_W), .ASID_W(ASID_W)) u_out (
      .clk(clk), .rst_n(rst_n), .commit(commit), .idx(idx), .epn_page(epn_page),
      .epn_asid(epn_asid), .epn_ev(epn_ev), .attr(attr), .rpn(sr_wdata),
      .tlb_we(tlb_we), .tlb_idx(tlb_idx), .tlb_epn(tlb_epn), .tlb_asid(tlb_asid),
      .tlb_ev(tlb_ev), .tlb_attr(tlb_attr), .tlb_rpn(tlb_rpn)
   );

   assign tlb_grp   = tlb_attr.grp;
   assign tlb_guard = tlb_attr.guard;
   assign tlb_size  = tlb_attr.size;
   assign tlb_wt    = tlb_attr.wt;
   assign tlb_sv    = tlb_attr.sv;
endmodule

// File: rtl/tw_tlb_loader_chk.sv
module tw_tlb_loader_chk
   import tw_pkg::*;
#(
   parameter int IDX_W   = 5,
   parameter int ASID_W  = 4,
   parameter int RSV_CNT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        sr_sel,
   input logic              sr_wr,
   input logic [31:0]       sr_wdata,
   input logic [31:0]       sr_rdata,
   input logic              miss_valid,
   input logic [19:0]       miss_page,
   input logic              tlb_we,
   input logic [31:0]       tlb_rpn,
   input logic [31:0]       ctrl_q,
   input logic [IDX_W-1:0]  idx,
   input logic [ASID_W-1:0] ctx_asid,
   input logic [19:0]       epn_page,
   input logic [ASID_W-1:0] epn_asid,
   input logic              epn_ev
);
   localparam logic [IDX_W-1:0] RSV_L = IDX_W'(RSV_CNT);

   // R8
   rpn_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr && sr_sel == SEL_RPN) |=> (tlb_we && tlb_rpn == $past(sr_wdata)));

   // R8
   no_stray_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_we |-> $past(sr_wr && sr_sel == SEL_RPN));

   // R5
   miss_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |=> (epn_page == $past(miss_page) && epn_asid == $past(ctx_asid) && epn_ev));

   // R10
   idx_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr && sr_sel == SEL_RPN && !ctrl_q[RSV_BIT]) |=> (idx == IDX_W'($past(idx) - 1'b1)));

   // R11
   rsv_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_wr && sr_sel == SEL_RPN && ctrl_q[RSV_BIT]) |=> (idx >= RSV_L));

   // R6
   l1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_sel == SEL_L1) |-> (sr_rdata[11:0] == {epn_page[19:10], 2'b00}));
endmodule

bind tw_tlb_loader tw_tlb_loader_chk #(.IDX_W(IDX_W), .ASID_W(ASID_W), .RSV_CNT(RSV_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .sr_sel(sr_sel), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
   .sr_rdata(sr_rdata), .miss_valid(miss_valid), .miss_page(miss_page),
   .tlb_we(tlb_we), .tlb_rpn(tlb_rpn), .ctrl_q(ctrl_q), .idx(idx),
   .ctx_asid(ctx_asid), .epn_page(epn_page), .epn_asid(epn_asid), .epn_ev(epn_ev)
);

// File: tb/tw_tlb_loader_test.sv
`timescale 1ns/1ps
module tw_tlb_loader_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  sr_sel;
   logic        sr_wr;
   logic [31:0] sr_wdata;
   logic [31:0] sr_rdata;
   logic        miss_valid;
   logic [19:0] miss_page;
   logic        tlb_we;
   logic [4:0]  tlb_idx;
   logic [19:0] tlb_epn;
   logic [3:0]  tlb_asid;
   logic        tlb_ev;
   logic [3:0]  tlb_grp;
   logic        tlb_guard;
   logic [1:0]  tlb_size;
   logic        tlb_wt;
   logic        tlb_sv;
   logic [31:0] tlb_rpn;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tw_tlb_loader uut (
      .clk(clk), .rst_n(rst_n), .sr_sel(sr_sel), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
      .sr_rdata(sr_rdata), .miss_valid(miss_valid), .miss_page(miss_page),
      .tlb_we(tlb_we), .tlb_idx(tlb_idx), .tlb_epn(tlb_epn), .tlb_asid(tlb_asid),
      .tlb_ev(tlb_ev), .tlb_grp(tlb_grp), .tlb_guard(tlb_guard), .tlb_size(tlb_size),
      .tlb_wt(tlb_wt), .tlb_sv(tlb_sv), .tlb_rpn(tlb_rpn)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      sr_sel = s; sr_wdata = d; sr_wr = 1'b1;
      @(negedge clk);
      sr_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [2:0] s, input logic [31:0] exp);
      sr_sel = s;
      #1;
      chk(req, sr_rdata, exp);
   endtask

   task automatic miss(input logic [19:0] p, input bit with_wr, input logic [31:0] d);
      @(negedge clk);
      miss_page = p; miss_valid = 1'b1;
      if (with_wr) begin sr_sel = 3'd2; sr_wdata = d; sr_wr = 1'b1; end
      @(negedge clk);
      miss_valid = 1'b0; sr_wr = 1'b0;
   endtask

   task automatic t_reset;
      rd("R1 ctrl", 3'd0, 32'h0400_0000);
      rd("R1 ctx", 3'd1, 32'h0);
      rd("R1 epn", 3'd2, 32'h0);
      rd("R1 l1", 3'd3, 32'h0);
      rd("R1 l2", 3'd4, 32'h0);
      chk("R1 tlb_we", {31'b0, tlb_we}, 32'h0);
   endtask

   task automatic t_regs;
      wr(3'd0, 32'h0000_1F00);
      rd("R2 ctrl readback", 3'd0, 32'h0000_1F00);
      wr(3'd0, 32'hFFFF_FFFF);
      rd("R2 ctrl all ones", 3'd0, 32'hFFFF_FFFF);
      wr(3'd1, 32'hFFFF_FFF5);
      rd("R3 ctx", 3'd1, 32'h0000_0005);
      wr(3'd2, 32'hFFFF_FFFF);
      rd("R4 epn mask", 3'd2, 32'hFFFF_F20F);
   endtask

   task automatic t_miss;
      miss(20'h12345, 1'b0, 32'h0);
      rd("R5 miss capture", 3'd2, 32'h1234_5205);
      miss(20'h0FF00, 1'b1, 32'hAAAA_A000);
      rd("R5 miss priority", 3'd2, 32'h0FF0_0205);
      miss(20'h12345, 1'b0, 32'h0);
   endtask

   task automatic t_addr;
      wr(3'd3, 32'hABCD_EFFF);
      rd("R6 l1 addr", 3'd3, {20'hABCDE, 10'h048, 2'b00});
      wr(3'd4, 32'h5555_51FF);
      rd("R7 l2 addr", 3'd4, {20'h55555, 10'h345, 2'b00});
   endtask

   task automatic t_entry;
      wr(3'd4, 32'h5555_515D);
      wr(3'd0, 32'h0000_0700);
      wr(3'd5, 32'hCAFE_B00F);
      chk("R8 we", {31'b0, tlb_we}, 32'h1);
      chk("R8 idx", {27'b0, tlb_idx}, 32'd7);
      chk("R8 epn", {12'b0, tlb_epn}, 32'h12345);
      chk("R8 asid/ev", {27'b0, tlb_ev, tlb_asid}, 32'h15);
      chk("R8 rpn", tlb_rpn, 32'hCAFE_B00F);
      chk("R9 attr a", {23'b0, tlb_grp, tlb_guard, tlb_size, tlb_wt, tlb_sv}, 32'h15D);
      rd("R10 idx dec", 3'd0, 32'h0000_0600);
      @(negedge clk);
      chk("R8 single pulse", {31'b0, tlb_we}, 32'h0);
      wr(3'd4, 32'h5555_5007);
      wr(3'd0, 32'h0000_0000);
      wr(3'd5, 32'h0000_1234);
      chk("R9 attr b", {23'b0, tlb_grp, tlb_guard, tlb_size, tlb_wt, tlb_sv}, 32'h007);
      chk("R10 idx zero", {27'b0, tlb_idx}, 32'd0);
      rd("R10 wrap", 3'd0, 32'h0000_1F00);
   endtask

   task automatic t_reserve;
      wr(3'd0, 32'h0800_0500);
      wr(3'd5, 32'h1);
      chk("R11 idx5", {27'b0, tlb_idx}, 32'd5);
      rd("R11 to 4", 3'd0, 32'h0800_0400);
      wr(3'd5, 32'h2);
      chk("R11 idx4", {27'b0, tlb_idx}, 32'd4);
      rd("R11 skip", 3'd0, 32'h0800_1F00);
      wr(3'd0, 32'h0800_0200);
      wr(3'd5, 32'h3);
      chk("R11 idx2", {27'b0, tlb_idx}, 32'd2);
      rd("R11 low skip", 3'd0, 32'h0800_1F00);
   endtask

   initial begin
      rst_n = 1'b0; sr_sel = 3'd0; sr_wr = 1'b0; sr_wdata = '0;
      miss_valid = 1'b0; miss_page = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_miss;
      t_addr;
      t_entry;
      t_reserve;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule